// File: doc/BRIEF.md
# Fine-Grained Thread Issue Selector

This block sits at the front of a single-issue, in-order pipeline shared by four hardware thread contexts. On every clock cycle it chooses one thread to issue an instruction. It moves to a different thread each cycle in round-robin order. Any thread that cannot issue is passed over: a thread may be waiting out a short load/branch penalty, waiting for a cache miss to return, or have no instruction ready. A bubble is issued only when no thread at all can go.

Each thread has a small tracker. The tracker holds a countdown that is loaded when that thread issues a load or a branch, and a flag that is set by a miss-start pulse and cleared by a miss-complete pulse. The selection itself is combinational from the registered tracker state, the registered round-robin pointer and the current instruction-available flags. The issue outputs are therefore valid in the same cycle as the availability inputs. The load/branch qualifier refers to the instruction being issued in that same cycle.

Top module: `fine_thread_sel`

## Requirements
- R1: While reset is asserted, issue_valid is 0. After reset every thread is eligible with no countdown and no pending miss, and the first thread chosen when all four have instructions is thread 0.
- R2: At most one thread issues per cycle. issue_tid is a binary thread number, and bit i of every per-thread vector belongs to thread i. When issue_valid is 1, the selected thread has its inst_avail bit set and is not stalled.
- R3: The search starts at the thread numbered one above the thread that issued most recently, wrapping from 3 to 0. With all threads ready, the issue order is 0,1,2,3,0.
- R4: When a thread issues with issue_is_lb high, that thread cannot issue in the following 3 cycles. It can issue again in the 4th cycle after the issue.
- R5: A miss_start pulse on a thread blocks that thread from the next cycle onward. The block stays in force through the cycle of its miss_done pulse, and the thread becomes eligible in the cycle after that pulse.
- R6: issue_valid is 0 only when no thread is both available and unstalled. During a bubble issue_tid reads 0 and the round-robin pointer keeps its value.
- R7: A thread whose inst_avail bit is low is skipped, but its penalty countdown keeps running as if it were available.
- R8: If miss_start and miss_done arrive on the same thread in the same cycle, the miss stays pending. A miss that completes while the penalty countdown is still running leaves the thread blocked until the countdown also expires.
- R9: issue_is_lb has no effect in a cycle in which issue_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_avail | input | NUM_THREADS | Per-thread flag: an instruction is ready to issue |
| issue_is_lb | input | 1 | The instruction issued this cycle is a load or a branch |
| miss_start | input | NUM_THREADS | Per-thread pulse: a cache miss has begun |
| miss_done | input | NUM_THREADS | Per-thread pulse: the outstanding miss has returned |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | $clog2(NUM_THREADS) | Number of the issuing thread, 0 during a bubble |

## Verification
The two stall sources of one thread can overlap, and two of these overlaps are provoked on purpose. In the first, a thread issues a load with its miss starting in the same cycle, and the miss completes while the 3-cycle countdown is still running. The bench then offers only that thread and expects bubbles until the countdown has run out, not merely until the miss has returned. In the second, miss_start and miss_done land on one thread in the same cycle. The bench expects the thread to stay blocked until a later, separate miss_done. The bench also checks that a load/branch qualifier raised during a bubble does not stall thread 0, which is the number shown on issue_tid at that time.

// File: rtl/fts_pkg.sv
package fts_pkg;

    localparam int unsigned FTS_THREADS_DEF = 4;
    localparam int unsigned FTS_PENALTY_DEF = 3;

    typedef enum logic {
        MISS_CLEAR   = 1'b0,
        MISS_PENDING = 1'b1
    } miss_state_e;

endpackage

// File: rtl/thread_stall_track.sv
module thread_stall_track
    import fts_pkg::*;
#(
    parameter int unsigned PENALTY = FTS_PENALTY_DEF,
    localparam int unsigned CW     = $clog2(PENALTY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lb_hit,
    input  logic miss_start,
    input  logic miss_done,
    output logic ready
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        miss_state_e   miss;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lb_hit) begin
            st_d.cnt = CW'(PENALTY);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (miss_start) begin
            st_d.miss = MISS_PENDING;
        end else if (miss_done) begin
            st_d.miss = MISS_CLEAR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, miss: MISS_CLEAR};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = (st_q.cnt == '0) && (st_q.miss == MISS_CLEAR);

    // R5
    miss_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_start |=> !ready);

    // R4
    lb_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_hit |=> !ready);

    // R8
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.miss == MISS_PENDING && !miss_done) |=> !ready);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(PENALTY));

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int unsigned N = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last_idx,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = N; k >= 1; k--) begin
            int cand;
            cand = (int'(last_idx) + k) % N;
            if (req[cand]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/fine_thread_sel.sv
module fine_thread_sel
    import fts_pkg::*;
#(
    parameter int unsigned NUM_THREADS = FTS_THREADS_DEF,
    parameter int unsigned PENALTY     = FTS_PENALTY_DEF,
    localparam int unsigned TW         = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] inst_avail,
    input  logic                   issue_is_lb,
    input  logic [NUM_THREADS-1:0] miss_start,
    input  logic [NUM_THREADS-1:0] miss_done,
    output logic                   issue_valid,
    output logic [TW-1:0]          issue_tid
);

    typedef struct packed {
        logic [TW-1:0] last;
    } sel_t;

    sel_t st_d, st_q;

    logic [NUM_THREADS-1:0] ready_vec;
    logic [NUM_THREADS-1:0] elig_vec;
    logic                   pick_valid;
    logic [TW-1:0]          pick_idx;

    assign elig_vec = ready_vec & inst_avail;

    rr_pick #(.N(NUM_THREADS)) u_pick (
        .req       (elig_vec),
        .last_idx  (st_q.last),
        .gnt_valid (pick_valid),
        .gnt_idx   (pick_idx)
    );

    assign issue_valid = rst_n & pick_valid;
    assign issue_tid   = issue_valid ? pick_idx : '0;

    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_trk
            logic lb_hit_t;
            assign lb_hit_t = issue_valid && issue_is_lb && (issue_tid == TW'(t));
            thread_stall_track #(.PENALTY(PENALTY)) u_trk (
                .clk        (clk),
                .rst_n      (rst_n),
                .lb_hit     (lb_hit_t),
                .miss_start (miss_start[t]),
                .miss_done  (miss_done[t]),
                .ready      (ready_vec[t])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (issue_valid) begin
            st_d.last = issue_tid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.last <= TW'(NUM_THREADS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    issue_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (inst_avail[issue_tid] && ready_vec[issue_tid]));

    // R6
    bubble_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> ((ready_vec & inst_avail) == '0));

    // R4
    lb_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue_valid && issue_is_lb) && issue_valid) |-> (issue_tid != $past(issue_tid)));

    // R6
    bubble_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (issue_tid == '0));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(st_q.last));

endmodule

// File: tb/fine_thread_sel_tb.sv
module fine_thread_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] inst_avail = '0;
    logic       issue_is_lb = 1'b0;
    logic [3:0] miss_start = '0;
    logic [3:0] miss_done = '0;
    logic       issue_valid;
    logic [1:0] issue_tid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fine_thread_sel dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .inst_avail  (inst_avail),
        .issue_is_lb (issue_is_lb),
        .miss_start  (miss_start),
        .miss_done   (miss_done),
        .issue_valid (issue_valid),
        .issue_tid   (issue_tid)
    );

    // {avail, lb, miss_start, miss_done, exp_valid, exp_tid}
    localparam int NV = 36;
    localparam logic [15:0] VEC [NV] = '{
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0},
        {4'b1111, 1'b1, 4'b0000, 4'b0000, 1'b1, 2'd1},
        {4'b0010, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0010, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0010, 1'b1, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0010, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1},
        {4'b0001, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1},
        {4'b1111, 1'b0, 4'b0100, 4'b0000, 1'b1, 2'd2},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3},
        {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0100, 1'b0, 4'b0000, 4'b0100, 1'b0, 2'd0},
        {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2},
        {4'b1111, 1'b0, 4'b0001, 4'b0001, 1'b1, 2'd3},
        {4'b0001, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0001, 1'b0, 4'b0000, 4'b0001, 1'b0, 2'd0},
        {4'b0001, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0},
        {4'b1111, 1'b1, 4'b0010, 4'b0000, 1'b1, 2'd1},
        {4'b0010, 1'b0, 4'b0000, 4'b0010, 1'b0, 2'd0},
        {4'b0010, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0010, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0010, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1},
        {4'b1111, 1'b1, 4'b0000, 4'b0000, 1'b1, 2'd2},
        {4'b1011, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3},
        {4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2},
        {4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b0, 2'd0},
        {4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd3}
    };

    function automatic string req_of(int v);
        if (v == 0)  return "R1";
        if (v <= 4)  return "R3";
        if (v <= 9)  return "R4";
        if (v == 10) return "R9";
        if (v <= 19) return "R5";
        if (v <= 28) return "R8";
        if (v <= 33) return "R7";
        return "R6";
    endfunction

    task automatic check_out(string req, logic ev, logic [1:0] et);
        checks++;
        if (issue_valid !== ev || issue_tid !== et) begin
            errors++;
            $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     req, issue_valid, issue_tid, ev, et);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        inst_avail = 4'b1111;
        #2 check_out("R1", 1'b0, 2'd0);          // R1: no issue during reset
        inst_avail = '0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {inst_avail, issue_is_lb, miss_start, miss_done} = VEC[v][15:3];
            #2 check_out(req_of(v), VEC[v][2], VEC[v][1:0]);
        end

        // R4 then R1: stall thread 0, reset, expect pointer and countdown cleared
        @(negedge clk);
        {inst_avail, issue_is_lb, miss_start, miss_done} = {4'b1111, 1'b1, 4'b0000, 4'b0000};
        #2 check_out("R4", 1'b1, 2'd0);
        @(negedge clk);
        rst_n = 1'b0;
        {inst_avail, issue_is_lb, miss_start, miss_done} = '0;
        #2 check_out("R1", 1'b0, 2'd0);
        @(negedge clk);
        rst_n = 1'b1;
        inst_avail = 4'b1111;
        #2 check_out("R1", 1'b1, 2'd0);
        @(negedge clk);
        inst_avail = 4'b1111;
        #2 check_out("R2", 1'b1, 2'd1);          // R2: single thread, rotation continues
        @(negedge clk);
        inst_avail = '0;

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule